// File: doc/BRIEF.md
# Registered Four-Operand Sum and AND Unit

This block takes four 8-bit operands, captures each one into its own register on every rising clock edge, and presents two results computed from those registered values. The first result is the arithmetic sum of the four operands, truncated to the operand width. The second result is the bitwise AND of the four operands. Both reductions run side by side on the same register bank.

The outputs are driven only by the register contents and never by the live inputs. A set of operands applied before a clock edge therefore shows up on both outputs just after that edge, one cycle later. The operands can change at any point between edges without disturbing the results. A synchronous active-high reset clears the register bank, and both outputs then read zero.

Top module: `quad_reduce_unit`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, all four operand registers clear, so `sum_o` and `and_o` both read 8'h00 after that edge.
- R2: When `rst` is low, every rising edge loads each operand input into its own register with no enable. The operands present before an edge decide both outputs right after that edge, which is a latency of one cycle.
- R3: `sum_o` is the sum of the four registered operands modulo 256. The carry out of bit 7 is discarded.
- R4: `and_o` is the bitwise AND of the four registered operands, bit by bit.
- R5: The outputs depend only on the registers. A change on any operand input between two edges leaves `sum_o` and `and_o` unchanged until the next rising edge.
- R6: When all four registered operands are 8'hFF, `and_o` reads 8'hFF and `sum_o` reads 8'hFC, which is the wrapped value of 4 x 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the operand registers |
| opnd0_i | input | 8 | Operand 0 |
| opnd1_i | input | 8 | Operand 1 |
| opnd2_i | input | 8 | Operand 2 |
| opnd3_i | input | 8 | Operand 3 |
| sum_o | output | 8 | Sum of the four registered operands, modulo 256 |
| and_o | output | 8 | Bitwise AND of the four registered operands |

## Verification
The assertions that compare the outputs with the operands sampled one edge earlier assume the operand inputs hold a settled, known value at each rising edge. They also assume that reset has been low for both that edge and the one before it. The bench meets these assumptions by changing operands only on falling edges, or during the high phase when it probes R5 after the sampling edge has passed. It keeps reset high across a whole clock period and starts the scoreboard only once reset is low again.

// File: rtl/quad_pkg.sv
package quad_pkg;
  // Default operand width and operand count for the reduction unit.
  localparam int unsigned OPND_W = 8;
  localparam int unsigned OPND_N = 4;
endpackage

// File: rtl/quad_capture.sv
module quad_capture #(
  parameter int unsigned W = quad_pkg::OPND_W,
  parameter int unsigned N = quad_pkg::OPND_N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0][W-1:0]  d_i,
  output logic [N-1:0][W-1:0]  q_o
);

  // One register per operand lane. The lanes load on every edge, with no enable.
  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) q_o[g] <= '0;
      else     q_o[g] <= d_i[g];
    end

    assert_lane_clear_R1 : assert property (@(posedge clk)
      rst |=> (q_o[g] == '0));

    assert_lane_load_R2 : assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (q_o[g] == $past(d_i[g])));
  end

endmodule

// File: rtl/quad_sum.sv
module quad_sum #(
  parameter int unsigned W = quad_pkg::OPND_W,
  parameter int unsigned N = quad_pkg::OPND_N
) (
  input  logic [N-1:0][W-1:0] opnd_i,
  output logic [W-1:0]        sum_o
);

  // A W-bit accumulator drops the carry at every step, which wraps the result modulo 2^W.
  always_comb begin
    sum_o = '0;
    for (int k = 0; k < int'(N); k++) begin
      sum_o = sum_o + opnd_i[k];
    end
  end

endmodule

// File: rtl/quad_and.sv
module quad_and #(
  parameter int unsigned W = quad_pkg::OPND_W,
  parameter int unsigned N = quad_pkg::OPND_N
) (
  input  logic [N-1:0][W-1:0] opnd_i,
  output logic [W-1:0]        and_o
);

  always_comb begin
    and_o = '1;
    for (int k = 0; k < int'(N); k++) begin
      and_o = and_o & opnd_i[k];
    end
  end

endmodule

// File: rtl/quad_reduce_unit.sv
module quad_reduce_unit #(
  parameter int unsigned W = quad_pkg::OPND_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd0_i,
  input  logic [W-1:0] opnd1_i,
  input  logic [W-1:0] opnd2_i,
  input  logic [W-1:0] opnd3_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] and_o
);

  localparam int unsigned N = 4;

  logic [N-1:0][W-1:0] live_opnd;
  logic [N-1:0][W-1:0] held_opnd;

  assign live_opnd = {opnd3_i, opnd2_i, opnd1_i, opnd0_i};

  quad_capture #(.W(W), .N(N)) i_capture (
    .clk (clk),
    .rst (rst),
    .d_i (live_opnd),
    .q_o (held_opnd)
  );

  quad_sum #(.W(W), .N(N)) i_sum (
    .opnd_i (held_opnd),
    .sum_o  (sum_o)
  );

  quad_and #(.W(W), .N(N)) i_and (
    .opnd_i (held_opnd),
    .and_o  (and_o)
  );

  // The output ports checked against the operand ports one edge earlier.
  assert_outputs_zero_R1 : assert property (@(posedge clk)
    rst |=> (sum_o == '0 && and_o == '0));

  assert_sum_wraps_R3 : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sum_o == W'($past(opnd0_i) + $past(opnd1_i)
                          + $past(opnd2_i) + $past(opnd3_i))));

  assert_and_bitwise_R4 : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (and_o == ($past(opnd0_i) & $past(opnd1_i)
                        & $past(opnd2_i) & $past(opnd3_i))));

  assert_all_ones_R6 : assert property (@(posedge clk) disable iff (rst)
    (and_o == {W{1'b1}}) |-> (sum_o == ({W{1'b1}} - W'(3))));

endmodule

// File: tb/test_quad_reduce_unit.sv
module test_quad_reduce_unit;

  typedef struct {
    logic [7:0] sum;
    logic [7:0] conj;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a = 8'h00, b = 8'h00, c = 8'h00, d = 8'h00;
  logic [7:0] sum_o, and_o;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  quad_reduce_unit i_quad_reduce_unit (
    .clk     (clk),
    .rst     (rst),
    .opnd0_i (a),
    .opnd1_i (b),
    .opnd2_i (c),
    .opnd3_i (d),
    .sum_o   (sum_o),
    .and_o   (and_o)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp_v);
    end
  endtask

  // Driver: applies operands on a falling edge and pushes the model's result.
  task automatic drive(input logic [7:0] va, vb, vc, vd, input string tag);
    int   s;
    exp_t e;
    @(negedge clk);
    a = va; b = vb; c = vc; d = vd;
    s      = int'(va) + int'(vb) + int'(vc) + int'(vd);
    e.sum  = 8'(s % 256);
    e.conj = va & vb & vc & vd;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: one cycle after the driver, pops the expected item and compares.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " sum"}, sum_o, e.sum);
        check({e.tag, " and"}, and_o, e.conj);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #20000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset with nonzero operands still clears the outputs.
    a = 8'h5A; b = 8'h33; c = 8'hF0; d = 8'h0F;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset sum", sum_o, 8'h00);
    check("R1 reset and", and_o, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    // R2/R3/R4: several distinct patterns.
    drive(8'h01, 8'h02, 8'h03, 8'h04, "R2 small");
    drive(8'h10, 8'h20, 8'h30, 8'h40, "R3 no wrap");
    drive(8'h80, 8'h80, 8'h01, 8'h02, "R3 wrap");
    drive(8'hF0, 8'h3C, 8'hFF, 8'h7E, "R4 mask");
    drive(8'hAA, 8'hAB, 8'hEA, 8'hAE, "R4 pattern");
    drive(8'h00, 8'hFF, 8'hFF, 8'hFF, "R4 one zero");
    drive(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R6 all ones");
    drive(8'hC0, 8'h40, 8'h00, 8'h00, "R3 exact 256");
    for (int i = 0; i < 24; i++) begin
      drive(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "R2 random");
    end

    // R5: disturb the inputs after the sampling edge; the outputs must hold.
    drive(8'h11, 8'h22, 8'h44, 8'h08, "R5 base");
    @(posedge clk);
    #2;
    a = 8'hFF; b = 8'hFF; c = 8'hFF; d = 8'hFF;
    #0.3;
    check("R5 hold sum", sum_o, 8'h7F);
    check("R5 hold and", and_o, 8'h00);

    // R6: explicit corner, applied once more so the monitor compares it.
    drive(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R6 corner");
    @(posedge clk);
    #2;

    // R1: reset in the middle of a run.
    @(negedge clk);
    a = 8'h77; b = 8'h77; c = 8'h77; d = 8'h77;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 midrun sum", sum_o, 8'h00);
    check("R1 midrun and", and_o, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    drive(8'h09, 8'h07, 8'h05, 8'h03, "R2 after reset");
    @(posedge clk);
    #2;
    finish_run();
  end

endmodule